// File: doc/BRIEF.md
# Token-Bus Transmit Command Sequencer

This block runs one host transmit command on a token-passing network. The host loads a packet into a buffer page elsewhere, waits for the transmit-available status bit, then issues an enable-transmit command naming the page and whether the message is a broadcast. The sequencer then waits for the node to hold the token. It probes the destination with a free-buffer enquiry, except for broadcasts. Then it asks the buffer logic to fetch the page, starts the packet frame, and updates the transmit-available and transmit-acknowledged status bits from the reply.

The enquiry reply has four outcomes, and each handles the token in its own way. A free buffer proceeds to the data. A refusal passes the token on and retries on the next visit. Silence ends the command. Noise keeps the token so that the network times out and reconfigures. Consecutive refusals are counted, and at a limit a diagnostic flag is raised. A disable command cancels the pending transmit at the next token visit. A level interrupt reports completion and the diagnostic flag, each under its own mask bit.

Top module: `token_tx_sequencer`

## Requirements
- R1: After reset, statTa is 1, statTma is 0, statExcNak is 0, and enqStart, fetchStart, pktStart and tokenPass are 0.
- R2: cmdEnable is accepted only while statTa is 1. Acceptance clears statTa and statTma in the next cycle and latches cmdPage and cmdBroadcast. An enable issued while statTa is 0 is ignored, and the page of the running command is kept.
- R3: For a non-broadcast command, a tokenHeld pulse produces a one-cycle enqStart in the next cycle, before any fetchStart or pktStart.
- R4: An enquiry reply of ACK (rspKind 2'b01) gives fetchStart in the next cycle, with pktPage equal to the latched page. fetchDone gives pktStart in the next cycle. A packet reply of ACK then sets statTa and statTma to 1 and pulses tokenPass.
- R5: A packet reply that is not ACK sets statTa to 1, leaves statTma at 0 and pulses tokenPass.
- R6: An enquiry reply of NAK (rspKind 2'b10) pulses tokenPass and keeps statTa at 0. The next tokenHeld sends the enquiry again.
- R7: statExcNak rises on the NAK_LIMIT-th consecutive enquiry NAK, where NAK_LIMIT defaults to 128. Any other enquiry outcome restarts the count. An accepted cmdEnable clears both the count and the flag.
- R8: An enquiry reply of no response (rspKind 2'b00) sets statTa to 1, leaves statTma at 0, pulses tokenPass, and makes no further enquiry on later tokens.
- R9: An enquiry reply of noise (rspKind 2'b11) does not pulse tokenPass and keeps the command pending with statTa at 0. The next tokenHeld sends the enquiry again.
- R10: cmdDisable while a command is pending makes the next tokenHeld set statTa to 1, leave statTma at 0, pulse tokenPass and send no enquiry. cmdDisable while statTa is 1 has no effect on a later command.
- R11: irq is high exactly when (statTa and maskDone) or (statExcNak and maskExcNak).
- R12: A broadcast command skips the enquiry: tokenHeld gives fetchStart in the next cycle. fetchDone gives pktStart, together with statTa 1, statTma 0 and a tokenPass pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdEnable | input | 1 | Enable-transmit command pulse |
| cmdPage | input | PAGE_W | Buffer page named by the command |
| cmdBroadcast | input | 1 | Command carries a broadcast message |
| cmdDisable | input | 1 | Disable-transmitter command pulse |
| tokenHeld | input | 1 | Node has just received the token |
| rspValid | input | 1 | A reply classification is present |
| rspKind | input | 2 | 00 none, 01 ACK, 10 NAK, 11 noise |
| fetchDone | input | 1 | Buffer fetch has finished |
| maskDone | input | 1 | Interrupt mask for transmit completion |
| maskExcNak | input | 1 | Interrupt mask for excessive refusals |
| enqStart | output | 1 | Start a free-buffer enquiry frame |
| fetchStart | output | 1 | Start the buffer fetch |
| pktPage | output | PAGE_W | Page to fetch |
| pktStart | output | 1 | Start the packet frame |
| tokenPass | output | 1 | Request to pass the token on |
| statTa | output | 1 | Transmit-available status |
| statTma | output | 1 | Transmit-acknowledged status |
| statExcNak | output | 1 | Excessive-refusal diagnostic flag |
| irq | output | 1 | Interrupt request |

## Verification
The situation hardest to reach from the ports is the excessive-refusal flag. It needs NAK_LIMIT consecutive enquiry refusals, each one on its own token visit. The bench loops a token-then-NAK task 128 times and checks that the flag is clear after the 127th refusal and set after the 128th. A second run places a noise reply partway through and then gives 127 more refusals, which shows that the count restarts.

// File: rtl/token_tx_pkg.sv
package token_tx_pkg;
  typedef enum logic [1:0] {
    RSP_NONE  = 2'b00,
    RSP_ACK   = 2'b01,
    RSP_NAK   = 2'b10,
    RSP_NOISE = 2'b11
  } rsp_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PEND, ST_WAIT_ENQ, ST_FETCH, ST_WAIT_PKT
  } state_e;

  typedef struct packed {
    logic loadCmd;
    logic sendEnq;
    logic sendFetch;
    logic sendPkt;
    logic passToken;
    logic finish;
    logic finishAck;
    logic nakSeen;
    logic nakClr;
  } strobes_t;
endpackage

// File: rtl/token_tx_ctrl.sv
module token_tx_ctrl
  import token_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdEnable,
  input  logic       tokenHeld,
  input  logic       rspValid,
  input  logic [1:0] rspKind,
  input  logic       fetchDone,
  input  logic       isBcast,
  input  logic       disPend,
  output strobes_t   stb
);
  state_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    stb = '0;
    unique case (state)
      ST_IDLE: begin
        if (cmdEnable) begin
          stb.loadCmd = 1'b1;
          stateNext = ST_PEND;
        end
      end
      ST_PEND: begin
        if (tokenHeld) begin
          if (disPend) begin
            stb.finish = 1'b1;
            stb.passToken = 1'b1;
            stateNext = ST_IDLE;
          end else if (isBcast) begin
            stb.sendFetch = 1'b1;
            stateNext = ST_FETCH;
          end else begin
            stb.sendEnq = 1'b1;
            stateNext = ST_WAIT_ENQ;
          end
        end
      end
      ST_WAIT_ENQ: begin
        if (rspValid) begin
          unique case (rsp_e'(rspKind))
            RSP_ACK: begin
              stb.nakClr = 1'b1;
              stb.sendFetch = 1'b1;
              stateNext = ST_FETCH;
            end
            RSP_NAK: begin
              stb.nakSeen = 1'b1;
              stb.passToken = 1'b1;
              stateNext = ST_PEND;
            end
            RSP_NONE: begin
              stb.nakClr = 1'b1;
              stb.finish = 1'b1;
              stb.passToken = 1'b1;
              stateNext = ST_IDLE;
            end
            default: begin
              // noise: keep the token, wait for the network to recover
              stb.nakClr = 1'b1;
              stateNext = ST_PEND;
            end
          endcase
        end
      end
      ST_FETCH: begin
        if (fetchDone) begin
          stb.sendPkt = 1'b1;
          if (isBcast) begin
            stb.finish = 1'b1;
            stb.passToken = 1'b1;
            stateNext = ST_IDLE;
          end else begin
            stateNext = ST_WAIT_PKT;
          end
        end
      end
      ST_WAIT_PKT: begin
        if (rspValid) begin
          stb.finish = 1'b1;
          stb.finishAck = (rsp_e'(rspKind) == RSP_ACK);
          stb.passToken = 1'b1;
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/token_tx_datapath.sv
module token_tx_datapath
  import token_tx_pkg::*;
#(
  parameter int PAGE_W    = 4,
  parameter int NAK_LIMIT = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [PAGE_W-1:0] cmdPage,
  input  logic              cmdBroadcast,
  input  logic              cmdDisable,
  input  logic              maskDone,
  input  logic              maskExcNak,
  output logic              isBcast,
  output logic              disPend,
  output logic [PAGE_W-1:0] pktPage,
  output logic              enqStart,
  output logic              fetchStart,
  output logic              pktStart,
  output logic              tokenPass,
  output logic              statTa,
  output logic              statTma,
  output logic              statExcNak,
  output logic              irq
);
  localparam int NAK_W = $clog2(NAK_LIMIT + 1);
  localparam logic [NAK_W-1:0] NAK_LAST = NAK_W'(NAK_LIMIT - 1);

  logic [NAK_W-1:0] nakCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statTa     <= 1'b1;
      statTma    <= 1'b0;
      statExcNak <= 1'b0;
      nakCnt     <= '0;
      pktPage    <= '0;
      isBcast    <= 1'b0;
      disPend    <= 1'b0;
      enqStart   <= 1'b0;
      fetchStart <= 1'b0;
      pktStart   <= 1'b0;
      tokenPass  <= 1'b0;
    end else begin
      enqStart   <= stb.sendEnq;
      fetchStart <= stb.sendFetch;
      pktStart   <= stb.sendPkt;
      tokenPass  <= stb.passToken;

      if (stb.loadCmd) begin
        statTa     <= 1'b0;
        statTma    <= 1'b0;
        statExcNak <= 1'b0;
        nakCnt     <= '0;
        pktPage    <= cmdPage;
        isBcast    <= cmdBroadcast;
        disPend    <= 1'b0;
      end else begin
        if (cmdDisable && !statTa) disPend <= 1'b1;
        if (stb.finish) begin
          statTa  <= 1'b1;
          statTma <= stb.finishAck;
          disPend <= 1'b0;
        end
        if (stb.nakClr) begin
          nakCnt <= '0;
        end else if (stb.nakSeen) begin
          if (nakCnt != NAK_W'(NAK_LIMIT)) nakCnt <= nakCnt + 1'b1;
          if (nakCnt == NAK_LAST) statExcNak <= 1'b1;
        end
      end
    end
  end

  assign irq = (statTa & maskDone) | (statExcNak & maskExcNak);
endmodule

// File: rtl/token_tx_sequencer.sv
module token_tx_sequencer
  import token_tx_pkg::*;
#(
  parameter int PAGE_W    = 4,
  parameter int NAK_LIMIT = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdEnable,
  input  logic [PAGE_W-1:0] cmdPage,
  input  logic              cmdBroadcast,
  input  logic              cmdDisable,
  input  logic              tokenHeld,
  input  logic              rspValid,
  input  logic [1:0]        rspKind,
  input  logic              fetchDone,
  input  logic              maskDone,
  input  logic              maskExcNak,
  output logic              enqStart,
  output logic              fetchStart,
  output logic [PAGE_W-1:0] pktPage,
  output logic              pktStart,
  output logic              tokenPass,
  output logic              statTa,
  output logic              statTma,
  output logic              statExcNak,
  output logic              irq
);
  strobes_t stb;
  logic isBcast, disPend;

  token_tx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdEnable(cmdEnable), .tokenHeld(tokenHeld),
    .rspValid(rspValid), .rspKind(rspKind), .fetchDone(fetchDone),
    .isBcast(isBcast), .disPend(disPend), .stb(stb)
  );

  token_tx_datapath #(.PAGE_W(PAGE_W), .NAK_LIMIT(NAK_LIMIT)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdPage(cmdPage),
    .cmdBroadcast(cmdBroadcast), .cmdDisable(cmdDisable),
    .maskDone(maskDone), .maskExcNak(maskExcNak), .isBcast(isBcast),
    .disPend(disPend), .pktPage(pktPage), .enqStart(enqStart),
    .fetchStart(fetchStart), .pktStart(pktStart), .tokenPass(tokenPass),
    .statTa(statTa), .statTma(statTma), .statExcNak(statExcNak), .irq(irq)
  );
endmodule

// File: rtl/token_tx_sequencer_chk.sv
module token_tx_sequencer_chk (
  input logic clk,
  input logic rstN,
  input logic cmdEnable,
  input logic enqStart,
  input logic fetchStart,
  input logic pktStart,
  input logic statTa,
  input logic statTma,
  input logic statExcNak,
  input logic maskExcNak,
  input logic irq
);
  p_enable_clears_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdEnable && statTa) |=> (!statTa && !statTma));

  p_one_frame_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({enqStart, fetchStart, pktStart}));

  p_tma_needs_ta_r4: assert property (@(posedge clk) disable iff (!rstN)
    statTma |-> statTa);

  p_flag_cleared_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdEnable && statTa) |=> !statExcNak);

  p_quiet_when_avail_r1: assert property (@(posedge clk) disable iff (!rstN)
    (statTa && $past(statTa)) |-> (!enqStart && !fetchStart));

  p_excnak_irq_r11: assert property (@(posedge clk) disable iff (!rstN)
    (statExcNak && maskExcNak) |-> irq);
endmodule

bind token_tx_sequencer token_tx_sequencer_chk u_chk (
  .clk(clk), .rstN(rstN), .cmdEnable(cmdEnable), .enqStart(enqStart),
  .fetchStart(fetchStart), .pktStart(pktStart), .statTa(statTa),
  .statTma(statTma), .statExcNak(statExcNak), .maskExcNak(maskExcNak),
  .irq(irq)
);

// File: tb/test_token_tx_sequencer.sv
`timescale 1ns/1ps
module test_token_tx_sequencer;
  localparam int PW = 4;
  logic clk = 1'b0, rstN = 1'b0;
  logic cmdEnable = 0, cmdBroadcast = 0, cmdDisable = 0, tokenHeld = 0;
  logic rspValid = 0, fetchDone = 0, maskDone = 0, maskExcNak = 0;
  logic [PW-1:0] cmdPage = '0;
  logic [1:0] rspKind = 2'b00;
  logic enqStart, fetchStart, pktStart, tokenPass, statTa, statTma, statExcNak, irq;
  logic [PW-1:0] pktPage;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  token_tx_sequencer #(.PAGE_W(PW), .NAK_LIMIT(128)) i_token_tx_sequencer (
    .clk(clk), .rstN(rstN), .cmdEnable(cmdEnable), .cmdPage(cmdPage),
    .cmdBroadcast(cmdBroadcast), .cmdDisable(cmdDisable), .tokenHeld(tokenHeld),
    .rspValid(rspValid), .rspKind(rspKind), .fetchDone(fetchDone),
    .maskDone(maskDone), .maskExcNak(maskExcNak), .enqStart(enqStart),
    .fetchStart(fetchStart), .pktPage(pktPage), .pktStart(pktStart),
    .tokenPass(tokenPass), .statTa(statTa), .statTma(statTma),
    .statExcNak(statExcNak), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic doEnable(input logic [PW-1:0] pg, input logic bc);
    cmdEnable = 1; cmdPage = pg; cmdBroadcast = bc; step(); cmdEnable = 0;
  endtask
  task automatic doToken(); tokenHeld = 1; step(); tokenHeld = 0; endtask
  task automatic doRsp(input logic [1:0] k);
    rspValid = 1; rspKind = k; step(); rspValid = 0;
  endtask
  task automatic doFetchDone(); fetchDone = 1; step(); fetchDone = 0; endtask
  task automatic doDisable(); cmdDisable = 1; step(); cmdDisable = 0; endtask

  task automatic t_reset();
    chk("R1 ta", statTa, 1); chk("R1 tma", statTma, 0);
    chk("R1 excnak", statExcNak, 0);
    chk("R1 strobes", {enqStart, fetchStart, pktStart, tokenPass}, 0);
  endtask

  task automatic t_unicast_ack();
    doEnable(4'd5, 0);
    chk("R2 ta cleared", statTa, 0); chk("R2 tma cleared", statTma, 0);
    doEnable(4'd9, 0);
    chk("R2 ignored enable keeps ta", statTa, 0);
    doToken();
    chk("R3 enquiry", enqStart, 1); chk("R3 no fetch yet", fetchStart, 0);
    doRsp(2'b01);
    chk("R4 fetch", fetchStart, 1); chk("R4 page kept R2", pktPage, 5);
    doFetchDone();
    chk("R4 pkt", pktStart, 1);
    doRsp(2'b01);
    chk("R4 ta", statTa, 1); chk("R4 tma", statTma, 1); chk("R4 pass", tokenPass, 1);
  endtask

  task automatic t_pkt_noresp();
    doEnable(4'd2, 0); doToken(); doRsp(2'b01); doFetchDone();
    doRsp(2'b00);
    chk("R5 ta", statTa, 1); chk("R5 tma", statTma, 0); chk("R5 pass", tokenPass, 1);
  endtask

  task automatic t_nak_then_ack();
    doEnable(4'd3, 0); doToken();
    doRsp(2'b10);
    chk("R6 pass", tokenPass, 1); chk("R6 ta", statTa, 0);
    doToken();
    chk("R6 re-enquiry", enqStart, 1);
    doRsp(2'b01); doFetchDone(); doRsp(2'b01);
    chk("R6 completes", statTma, 1);
  endtask

  task automatic t_enq_none();
    doEnable(4'd4, 0); doToken();
    doRsp(2'b00);
    chk("R8 ta", statTa, 1); chk("R8 tma", statTma, 0); chk("R8 pass", tokenPass, 1);
    doToken();
    chk("R8 no retry", enqStart, 0);
  endtask

  task automatic t_noise();
    doEnable(4'd6, 0); doToken();
    doRsp(2'b11);
    chk("R9 no pass", tokenPass, 0); chk("R9 ta", statTa, 0);
    doToken();
    chk("R9 re-enquiry", enqStart, 1);
    doRsp(2'b00);
  endtask

  task automatic t_disable();
    doDisable();
    doEnable(4'd7, 0); doToken();
    chk("R10 idle disable ignored", enqStart, 1);
    doRsp(2'b10);
    doDisable();
    doToken();
    chk("R10 no enquiry", enqStart, 0); chk("R10 ta", statTa, 1);
    chk("R10 tma", statTma, 0); chk("R10 pass", tokenPass, 1);
  endtask

  task automatic t_broadcast();
    doEnable(4'd10, 1); doToken();
    chk("R12 no enquiry", enqStart, 0); chk("R12 fetch", fetchStart, 1);
    chk("R12 page", pktPage, 10);
    doFetchDone();
    chk("R12 pkt", pktStart, 1); chk("R12 ta", statTa, 1);
    chk("R12 tma", statTma, 0); chk("R12 pass", tokenPass, 1);
  endtask

  task automatic t_excnak();
    doEnable(4'd1, 0);
    for (int i = 0; i < 127; i++) begin doToken(); doRsp(2'b10); end
    chk("R7 below limit", statExcNak, 0);
    doToken(); doRsp(2'b10);
    chk("R7 at limit", statExcNak, 1);
    maskExcNak = 1; step();
    chk("R11 excnak irq", irq, 1);
    maskExcNak = 0; step();
    chk("R11 masked", irq, 0);
    doDisable(); doToken();
    doEnable(4'd1, 0);
    chk("R7 cleared by enable", statExcNak, 0);
    for (int i = 0; i < 100; i++) begin doToken(); doRsp(2'b10); end
    doToken(); doRsp(2'b11);
    for (int i = 0; i < 127; i++) begin doToken(); doRsp(2'b10); end
    chk("R7 count restarted", statExcNak, 0);
    doToken(); doRsp(2'b00);
  endtask

  task automatic t_irq();
    maskDone = 0; step();
    chk("R11 done masked", irq, 0);
    maskDone = 1; step();
    chk("R11 done irq", irq, 1);
    doEnable(4'd0, 1);
    chk("R11 pending no irq", irq, 0);
    doToken(); doFetchDone();
    chk("R11 irq on completion", irq, 1);
    maskDone = 0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step(); step(); rstN = 1; step();
    t_reset();
    t_unicast_ack();
    t_pkt_noresp();
    t_nak_then_ack();
    t_enq_none();
    t_noise();
    t_disable();
    t_broadcast();
    t_excnak();
    t_irq();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule